// File: doc/BRIEF.md
# Segment Register Hidden-Cache Loader

This block owns a small bank of segment registers. Each register holds a visible 16-bit selector and three hidden fields: a 32-bit base, a 32-bit byte limit and an 8-bit access byte. A load request names a target register and a selector. The current protection-enable input picks how the hidden fields are filled.

With protection disabled, the load finishes in one cycle. The base becomes the selector times 16, and the limit and access byte keep the values they already had. The one exception is the code register, which is forced to a writable data type. With protection enabled, the block issues one 64-bit read to a descriptor table, decodes the descriptor that comes back and writes all hidden fields from it. A descriptor that is not present raises a fault and changes nothing.

Because a real-mode load keeps the limit, a 4 GB limit that was loaded while protection was on stays in place after protection is turned off. This gives flat access to the whole address space. Changing the protection input by itself never changes any register; only a load does.

Top module: `seg_cache_loader`

## Requirements
- R1: After reset, every register has selector 0, base 0, limit 0x0000FFFF and access byte 0x93.
- R2: A request with protection off is accepted when no table read is pending. At the same clock edge it writes the target selector and sets the base to {12'b0, selector, 4'b0000}. done_o is high for the following cycle.
- R3: A request with protection off leaves the limit and access byte of a non-code register unchanged.
- R4: A request with protection off to the code register (index 1) sets its access byte to 0x93 and leaves its limit unchanged.
- R5: A request with protection on raises tbl_req_o from the next cycle with tbl_addr_o = selector[15:3]. Both hold steady until tbl_valid_i is seen.
- R6: When the read returns, the descriptor fields are base = bits [31:0], raw limit = bits [51:32], granularity = bit 52 and access byte = bits [63:56]. The selector and all three hidden fields are written, and done_o is high for the cycle after tbl_valid_i.
- R7: With granularity 0 the limit is {12'b0, raw}. With granularity 1 it is {raw, 12'hFFF}.
- R8: A descriptor whose access byte bit 7 (present) is clear gives a one-cycle fault_o pulse, no done_o pulse, and leaves the register unchanged.
- R9: A limit of 0xFFFFFFFF loaded with protection on survives later loads with protection off.
- R10: Changing prot_en_i without a request changes no output field.
- R11: A request that arrives while a table read is pending is dropped.
- R12: A load writes only the register it targets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_req_i | input | 1 | Load request, one cycle |
| sel_i | input | 16 | Selector to load |
| seg_idx_i | input | 3 | Target register index |
| prot_en_i | input | 1 | Protection-enable mode bit |
| tbl_req_o | output | 1 | Descriptor read pending |
| tbl_addr_o | output | 13 | Descriptor index |
| tbl_valid_i | input | 1 | Descriptor data valid |
| tbl_data_i | input | 64 | Descriptor data |
| sel_o | output | 96 | Selectors, register i at [16i +: 16] |
| base_o | output | 192 | Hidden bases, register i at [32i +: 32] |
| limit_o | output | 192 | Hidden byte limits, register i at [32i +: 32] |
| attr_o | output | 48 | Hidden access bytes, register i at [8i +: 8] |
| done_o | output | 1 | Load completed pulse |
| fault_o | output | 1 | Not-present fault pulse |

## Verification
The bench goes after the 4 GB limit surviving a real-mode reload. A design that copies a default limit on every real-mode load would drop it back to 64 KB. A code-register load without protection is checked for the forced writable-data access byte and the limit it keeps; a design that treats the code register like the others would keep a code type there. Not-present descriptors, granularity scaling and requests made during a pending read are each checked. A wrong design would corrupt the register, report the limit in the wrong units, or start a second load.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam logic [7:0]  ATTR_RW_DATA = 8'h93;
  localparam logic [31:0] LIMIT_RST    = 32'h0000_FFFF;

  typedef enum logic {ST_IDLE, ST_WAIT} ld_state_e;

  typedef struct packed {
    logic [31:0] base;
    logic [31:0] limit;
    logic [7:0]  attr;
    logic        present;
  } desc_t;
endpackage

// File: rtl/seg_desc_decode.sv
module seg_desc_decode
  import seg_pkg::*;
(
  input  logic [63:0] desc_i,
  output desc_t       desc_o
);
  logic unused_rsvd;
  assign unused_rsvd = ^desc_i[55:53];

  always_comb begin
    desc_o.base    = desc_i[31:0];
    desc_o.attr    = desc_i[63:56];
    desc_o.present = desc_i[63];
    // granularity scales the 20-bit limit to 4 KB pages
    desc_o.limit   = desc_i[52] ? {desc_i[51:32], 12'hFFF} : {12'h000, desc_i[51:32]};
  end
endmodule

// File: rtl/seg_load_ctrl.sv
module seg_load_ctrl
  import seg_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_req_i,
  input  logic             prot_en_i,
  input  logic [15:0]      sel_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             tbl_valid_i,
  input  logic             present_i,
  output logic             tbl_req_o,
  output logic [12:0]      tbl_addr_o,
  output logic             wr_real_o,
  output logic             wr_desc_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [15:0]      wr_sel_o,
  output logic             done_o,
  output logic             fault_o
);
  ld_state_e        state_q;
  logic [15:0]      sel_q;
  logic [IDX_W-1:0] idx_q;
  logic             idle;

  assign idle       = (state_q == ST_IDLE);
  assign wr_real_o  = idle && load_req_i && !prot_en_i;
  assign wr_desc_o  = !idle && tbl_valid_i && present_i;
  assign wr_idx_o   = idle ? idx_i : idx_q;
  assign wr_sel_o   = idle ? sel_i : sel_q;
  assign tbl_req_o  = !idle;
  assign tbl_addr_o = sel_q[15:3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
      idx_q   <= '0;
      done_o  <= 1'b0;
      fault_o <= 1'b0;
    end else begin
      done_o  <= wr_real_o || wr_desc_o;
      fault_o <= !idle && tbl_valid_i && !present_i;
      if (idle) begin
        if (load_req_i && prot_en_i) begin
          state_q <= ST_WAIT;
          sel_q   <= sel_i;
          idx_q   <= idx_i;
        end
      end else if (tbl_valid_i) begin
        state_q <= ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/seg_reg_bank.sv
module seg_reg_bank
  import seg_pkg::*;
#(
  parameter int NUM_SEGS = 6,
  parameter int CODE_IDX = 1,
  parameter int IDX_W    = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_real_i,
  input  logic                   wr_desc_i,
  input  logic [IDX_W-1:0]       wr_idx_i,
  input  logic [15:0]            wr_sel_i,
  input  desc_t                  desc_i,
  output logic [NUM_SEGS*16-1:0] sel_o,
  output logic [NUM_SEGS*32-1:0] base_o,
  output logic [NUM_SEGS*32-1:0] limit_o,
  output logic [NUM_SEGS*8-1:0]  attr_o
);
  for (genvar i = 0; i < NUM_SEGS; i++) begin : g_seg
    logic hit;
    assign hit = (wr_idx_i == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sel_o[i*16 +: 16]  <= '0;
        base_o[i*32 +: 32] <= '0;
        limit_o[i*32 +: 32] <= LIMIT_RST;
        attr_o[i*8 +: 8]   <= ATTR_RW_DATA;
      end else if (hit && wr_real_i) begin
        // real-mode load: base only, limit kept
        sel_o[i*16 +: 16]  <= wr_sel_i;
        base_o[i*32 +: 32] <= {12'h000, wr_sel_i, 4'h0};
        if (i == CODE_IDX) attr_o[i*8 +: 8] <= ATTR_RW_DATA;
      end else if (hit && wr_desc_i) begin
        sel_o[i*16 +: 16]   <= wr_sel_i;
        base_o[i*32 +: 32]  <= desc_i.base;
        limit_o[i*32 +: 32] <= desc_i.limit;
        attr_o[i*8 +: 8]    <= desc_i.attr;
      end
    end
  end
endmodule

// File: rtl/seg_cache_loader.sv
module seg_cache_loader
  import seg_pkg::*;
#(
  parameter int NUM_SEGS = 6,
  parameter int CODE_IDX = 1,
  localparam int IDX_W   = $clog2(NUM_SEGS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_req_i,
  input  logic [15:0]            sel_i,
  input  logic [IDX_W-1:0]       seg_idx_i,
  input  logic                   prot_en_i,
  output logic                   tbl_req_o,
  output logic [12:0]            tbl_addr_o,
  input  logic                   tbl_valid_i,
  input  logic [63:0]            tbl_data_i,
  output logic [NUM_SEGS*16-1:0] sel_o,
  output logic [NUM_SEGS*32-1:0] base_o,
  output logic [NUM_SEGS*32-1:0] limit_o,
  output logic [NUM_SEGS*8-1:0]  attr_o,
  output logic                   done_o,
  output logic                   fault_o
);
  desc_t            desc;
  logic             wr_real, wr_desc;
  logic [IDX_W-1:0] wr_idx;
  logic [15:0]      wr_sel;

  seg_desc_decode u_dec (
    .desc_i (tbl_data_i),
    .desc_o (desc)
  );

  seg_load_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_req_i  (load_req_i),
    .prot_en_i   (prot_en_i),
    .sel_i       (sel_i),
    .idx_i       (seg_idx_i),
    .tbl_valid_i (tbl_valid_i),
    .present_i   (desc.present),
    .tbl_req_o   (tbl_req_o),
    .tbl_addr_o  (tbl_addr_o),
    .wr_real_o   (wr_real),
    .wr_desc_o   (wr_desc),
    .wr_idx_o    (wr_idx),
    .wr_sel_o    (wr_sel),
    .done_o      (done_o),
    .fault_o     (fault_o)
  );

  seg_reg_bank #(.NUM_SEGS(NUM_SEGS), .CODE_IDX(CODE_IDX), .IDX_W(IDX_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_real_i (wr_real),
    .wr_desc_i (wr_desc),
    .wr_idx_i  (wr_idx),
    .wr_sel_i  (wr_sel),
    .desc_i    (desc),
    .sel_o     (sel_o),
    .base_o    (base_o),
    .limit_o   (limit_o),
    .attr_o    (attr_o)
  );
endmodule

// File: rtl/seg_cache_loader_chk.sv
module seg_cache_loader_chk #(
  parameter int NUM_SEGS = 6,
  localparam int IDX_W   = $clog2(NUM_SEGS)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   load_req_i,
  input logic                   prot_en_i,
  input logic                   tbl_req_o,
  input logic [12:0]            tbl_addr_o,
  input logic                   tbl_valid_i,
  input logic [NUM_SEGS*16-1:0] sel_o,
  input logic [NUM_SEGS*32-1:0] base_o,
  input logic [NUM_SEGS*32-1:0] limit_o,
  input logic [NUM_SEGS*8-1:0]  attr_o,
  input logic                   done_o,
  input logic                   fault_o
);
  a_r2_real_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_req_i && !prot_en_i && !tbl_req_o |=> done_o);

  a_r5_fetch_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_req_i && prot_en_i && !tbl_req_o |=> tbl_req_o);

  a_r5_fetch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_req_o && !tbl_valid_i |=> tbl_req_o && $stable(tbl_addr_o));

  a_r8_done_fault_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fault_o));

  // R8, R10: hidden state moves only on a completed load
  a_r10_quiet_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(sel_o) && $stable(base_o) && $stable(limit_o) && $stable(attr_o));
endmodule

bind seg_cache_loader seg_cache_loader_chk #(.NUM_SEGS(NUM_SEGS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .load_req_i  (load_req_i),
  .prot_en_i   (prot_en_i),
  .tbl_req_o   (tbl_req_o),
  .tbl_addr_o  (tbl_addr_o),
  .tbl_valid_i (tbl_valid_i),
  .sel_o       (sel_o),
  .base_o      (base_o),
  .limit_o     (limit_o),
  .attr_o      (attr_o),
  .done_o      (done_o),
  .fault_o     (fault_o)
);

// File: tb/sim_seg_cache_loader.sv
`timescale 1ns/1ps
module sim_seg_cache_loader;
  localparam int NS = 6;
  localparam int NV = 9;

  logic                clk_i = 1'b0;
  logic                rst_ni = 1'b0;
  logic                load_req_i = 1'b0;
  logic [15:0]         sel_i = '0;
  logic [2:0]          seg_idx_i = '0;
  logic                prot_en_i = 1'b0;
  logic                tbl_req_o;
  logic [12:0]         tbl_addr_o;
  logic                tbl_valid_i = 1'b0;
  logic [63:0]         tbl_data_i = '0;
  logic [NS*16-1:0]    sel_o;
  logic [NS*32-1:0]    base_o;
  logic [NS*32-1:0]    limit_o;
  logic [NS*8-1:0]     attr_o;
  logic                done_o;
  logic                fault_o;

  int tests = 0;
  int fails = 0;

  logic [15:0] m_sel  [NS];
  logic [31:0] m_base [NS];
  logic [31:0] m_lim  [NS];
  logic [7:0]  m_attr [NS];

  // {exp_fault, prot, idx, sel, descriptor}
  localparam logic [84:0] VEC [NV] = '{
    {1'b0, 1'b0, 3'd0, 16'h1234, 64'h0},                    // R2 R3
    {1'b0, 1'b0, 3'd1, 16'hF000, 64'h0},                    // R4
    {1'b0, 1'b1, 3'd2, 16'h0010, 64'h9200FFFF_00100000},    // R6 byte limit
    {1'b0, 1'b1, 3'd3, 16'h0018, 64'h921FFFFF_00000000},    // R7 4 GB
    {1'b1, 1'b1, 3'd4, 16'h0020, 64'h1200FFFF_12345678},    // R8 not present
    {1'b0, 1'b1, 3'd1, 16'h0008, 64'h9A1FFFFF_00000000},    // R6 code
    {1'b0, 1'b0, 3'd3, 16'h0040, 64'h0},                    // R9
    {1'b0, 1'b0, 3'd1, 16'h2000, 64'h0},                    // R4 R9
    {1'b0, 1'b0, 3'd5, 16'hFFFF, 64'h0}                     // R2 top selector
  };

  seg_cache_loader u0 (.*);

  always #4 clk_i = ~clk_i;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // R12: every register compared, not only the target
  task automatic check_all(string tag);
    for (int i = 0; i < NS; i++) begin
      chk({tag, " sel"},   64'(sel_o[i*16 +: 16]),  64'(m_sel[i]));
      chk({tag, " base"},  64'(base_o[i*32 +: 32]), 64'(m_base[i]));
      chk({tag, " limit"}, 64'(limit_o[i*32 +: 32]), 64'(m_lim[i]));
      chk({tag, " attr"},  64'(attr_o[i*8 +: 8]),   64'(m_attr[i]));
    end
  endtask

  task automatic model_real(int idx, logic [15:0] s);
    m_sel[idx]  = s;
    m_base[idx] = {12'h0, s, 4'h0};
    if (idx == 1) m_attr[idx] = 8'h93;
  endtask

  task automatic model_desc(int idx, logic [15:0] s, logic [63:0] d);
    if (d[63]) begin
      m_sel[idx]  = s;
      m_base[idx] = d[31:0];
      m_lim[idx]  = d[52] ? {d[51:32], 12'hFFF} : {12'h0, d[51:32]};
      m_attr[idx] = d[63:56];
    end
  endtask

  // called at a negedge
  task automatic do_load(logic prot, int idx, logic [15:0] s, logic [63:0] d, logic exp_fault);
    load_req_i = 1'b1; prot_en_i = prot; seg_idx_i = 3'(idx); sel_i = s;
    @(posedge clk_i); @(negedge clk_i);
    load_req_i = 1'b0;
    if (!prot) begin
      chk("R2 done", 64'(done_o), 64'd1);
      model_real(idx, s);
    end else begin
      chk("R5 req", 64'(tbl_req_o), 64'd1);
      chk("R5 addr", 64'(tbl_addr_o), 64'(s[15:3]));
      tbl_valid_i = 1'b1; tbl_data_i = d;
      @(posedge clk_i); @(negedge clk_i);
      tbl_valid_i = 1'b0;
      chk("R6 done", 64'(done_o), 64'(!exp_fault));
      chk("R8 fault", 64'(fault_o), 64'(exp_fault));
      chk("R5 req drop", 64'(tbl_req_o), 64'd0);
      model_desc(idx, s, d);
    end
    check_all(prot ? "R6 R7 R8 R12" : "R3 R4 R9 R12");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NS; i++) begin
      m_sel[i] = '0; m_base[i] = '0; m_lim[i] = 32'h0000FFFF; m_attr[i] = 8'h93;
    end
    repeat (3) @(negedge clk_i);
    check_all("R1 reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 done idle", 64'(done_o), 64'd0);
    chk("R1 req idle", 64'(tbl_req_o), 64'd0);

    for (int v = 0; v < NV; v++)
      do_load(VEC[v][83], int'(VEC[v][82:80]), VEC[v][79:64], VEC[v][63:0], VEC[v][84]);

    // R10: mode bit toggling alone
    prot_en_i = 1'b1; @(negedge clk_i);
    prot_en_i = 1'b0; @(negedge clk_i);
    prot_en_i = 1'b1; @(negedge clk_i);
    chk("R10 done", 64'(done_o), 64'd0);
    check_all("R10");

    // R11: request during a pending read is dropped; R5 held while waiting
    load_req_i = 1'b1; prot_en_i = 1'b1; seg_idx_i = 3'd0; sel_i = 16'h0030;
    @(posedge clk_i); @(negedge clk_i);
    load_req_i = 1'b1; prot_en_i = 1'b0; seg_idx_i = 3'd2; sel_i = 16'h5555;
    @(posedge clk_i); @(negedge clk_i);
    load_req_i = 1'b0;
    chk("R11 no done", 64'(done_o), 64'd0);
    chk("R5 held req", 64'(tbl_req_o), 64'd1);
    chk("R5 held addr", 64'(tbl_addr_o), 64'h6);
    check_all("R11 pending");
    tbl_valid_i = 1'b1; tbl_data_i = 64'h9300ABCD_00020000;
    @(posedge clk_i); @(negedge clk_i);
    tbl_valid_i = 1'b0;
    chk("R11 done", 64'(done_o), 64'd1);
    model_desc(0, 16'h0030, 64'h9300ABCD_00020000);
    check_all("R11 R12");

    // R8: pulse lasts one cycle
    do_load(1'b1, 2, 16'h0050, 64'h0200FFFF_00000000, 1'b1);
    @(negedge clk_i);
    chk("R8 fault pulse", 64'(fault_o), 64'd0);

    // R9: real-mode reload of the code register keeps its 4 GB limit
    do_load(1'b0, 1, 16'h0001, 64'h0, 1'b0);
    chk("R9 code limit", 64'(limit_o[1*32 +: 32]), 64'hFFFFFFFF);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule